// File: doc/BRIEF.md
# Ultra DMA Data-In Burst Launcher (Device Side)

This block is the device end of a 16-bit parallel-bus Ultra DMA read. It opens a data-in burst in the order the protocol requires. When a local word source offers data, the block raises its request to the host. It waits for the host acknowledge. It then waits until the host has lowered its stop line and signalled that it is ready. Only then does it put the first word on the bus. After a setup wait, it makes the first falling strobe edge, which hands that word to the host.

Three integer parameters set the minimum waits, each counted in clock cycles:
- the time from acknowledge until the device starts driving its strobe line;
- the time from the host being ready until the device turns on its data drivers;
- the time the data must be stable before the strobe falls.

The data bus and the strobe line each have their own output-enable. Once the strobe has been driven, it stays driven until the host withdraws acknowledge. If the host withdraws acknowledge before the first strobe edge, the block releases everything and goes idle without consuming the word.

Top module: `udma_burst_launch`

## Requirements
- R1: While reset is held, and on the first cycle after it, dev_req, dev_strobe_oe, bus_data_oe and src_take are all 0.
- R2: From idle, dev_req goes to 1 one clock edge after src_valid is sampled at 1. It stays 1 until host_ack_n is sampled at 1 after an acknowledge. It falls on that same edge.
- R3: Before host_ack_n is sampled low, the levels on host_stop and host_rdy_n have no effect. bus_data_oe stays 0 even if both are already at their ready levels (host_stop=0, host_rdy_n=0).
- R4: dev_strobe_oe goes to 1, with dev_strobe=1, exactly STB_EN_CYC edges after the edge that first samples host_ack_n=0. The strobe is never driven while dev_req is 0.
- R5: bus_data_oe goes to 1 exactly DATA_EN_CYC edges after the first edge, following acknowledge, that samples host_ack_n=0, host_stop=0 and host_rdy_n=0 together. bus_data then carries the src_word value sampled on that enabling edge.
- R6: While host_stop=1 or host_rdy_n=1, bus_data_oe stays 0.
- R7: dev_strobe falls from 1 to 0 on the edge max(ED+SETUP_CYC, ES+1). Here ED is the edge where bus_data_oe rose and ES is the edge where dev_strobe_oe rose. src_take is 1 for exactly the one cycle that follows that edge.
- R8: dev_strobe_oe stays 1 for as long as host_ack_n stays 0, including after the first strobe edge.
- R9: On the edge that samples host_ack_n=1 after an acknowledge, dev_req, bus_data_oe and dev_strobe_oe all drop to 0.
- R10: If acknowledge is withdrawn before the first strobe edge, src_take never pulses. The block returns to idle.
- R11: While bus_data_oe stays 1, bus_data does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Local source has a word to send |
| src_word | input | DW | Word offered by the source |
| src_take | output | 1 | One-cycle pulse when the first word has been transferred |
| dev_req | output | 1 | Device DMA request to the host |
| host_ack_n | input | 1 | Host DMA acknowledge, active low |
| host_stop | input | 1 | Host stop line (meaningful only while acknowledged) |
| host_rdy_n | input | 1 | Host ready line, active low (meaningful only while acknowledged) |
| bus_data | output | DW | Data bus value |
| bus_data_oe | output | 1 | Data bus output enable |
| dev_strobe | output | 1 | Device strobe level |
| dev_strobe_oe | output | 1 | Device strobe output enable |

## Verification
The assertions assume that the host follows the protocol:
- acknowledge arrives only while a request is up;
- the stop and ready lines, once at their ready levels, stay there until the first strobe edge;
- the source holds its word steady while a burst is being set up.

The bench drives every host line at mid-cycle and keeps each one at a fixed level from when it is set until release. It sweeps the acknowledge delay, the ready delay and an early-abort option. The zero-delay ready case puts the lines at their ready levels before acknowledge, so the window rule is exercised under the same stable-input assumption.

// File: rtl/udma_burst_launch.sv
module udma_burst_launch #(
  parameter int DW          = 16,
  parameter int STB_EN_CYC  = 3,
  parameter int DATA_EN_CYC = 2,
  parameter int SETUP_CYC   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_valid,
  input  logic [DW-1:0] src_word,
  output logic          src_take,
  output logic          dev_req,
  input  logic          host_ack_n,
  input  logic          host_stop,
  input  logic          host_rdy_n,
  output logic [DW-1:0] bus_data,
  output logic          bus_data_oe,
  output logic          dev_strobe,
  output logic          dev_strobe_oe
);
  localparam int MAXC = (STB_EN_CYC > DATA_EN_CYC) ?
                        ((STB_EN_CYC > SETUP_CYC) ? STB_EN_CYC : SETUP_CYC) :
                        ((DATA_EN_CYC > SETUP_CYC) ? DATA_EN_CYC : SETUP_CYC);
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_WACK, S_WRDY, S_DEN, S_SETUP, S_HOLD} st_t;
  st_t st;
  logic [CW-1:0] cnt, scnt;

  wire in_window = dev_req & ~host_ack_n;
  wire host_go   = in_window & ~host_stop & ~host_rdy_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; dev_req <= 1'b0; cnt <= '0; scnt <= '0;
      dev_strobe_oe <= 1'b0; dev_strobe <= 1'b0;
      bus_data_oe <= 1'b0; bus_data <= '0; src_take <= 1'b0;
    end else begin
      src_take <= 1'b0;
      case (st)
        S_IDLE: if (src_valid) begin
          dev_req <= 1'b1;
          st <= S_WACK;
        end
        S_WACK: if (in_window) begin
          scnt <= CW'(STB_EN_CYC - 1);
          st <= S_WRDY;
        end
        default: begin
          if (host_ack_n) begin
            dev_req <= 1'b0; dev_strobe_oe <= 1'b0; dev_strobe <= 1'b0;
            bus_data_oe <= 1'b0;
            st <= S_IDLE;
          end else begin
            if (!dev_strobe_oe) begin
              if (scnt == '0) begin
                dev_strobe_oe <= 1'b1;
                dev_strobe <= 1'b1;
              end else scnt <= scnt - 1'b1;
            end
            case (st)
              S_WRDY: if (host_go) begin
                cnt <= CW'(DATA_EN_CYC - 1);
                st <= S_DEN;
              end
              S_DEN: if (cnt == '0) begin
                bus_data_oe <= 1'b1;
                bus_data <= src_word;
                cnt <= CW'(SETUP_CYC - 1);
                st <= S_SETUP;
              end else cnt <= cnt - 1'b1;
              S_SETUP: if (cnt != '0) cnt <= cnt - 1'b1;
                else if (dev_strobe_oe) begin
                  dev_strobe <= 1'b0;
                  src_take <= 1'b1;
                  st <= S_HOLD;
                end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  // R4
  strobe_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_strobe_oe |-> dev_req);
  // R8
  strobe_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_strobe_oe && !host_ack_n) |=> dev_strobe_oe);
  // R7
  first_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_take |-> (!dev_strobe && bus_data_oe && $past(dev_strobe)));
  // R11
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_data_oe && $past(bus_data_oe)) |-> $stable(bus_data));
  // R2
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_req) |-> $past(host_ack_n));
endmodule

// File: tb/udma_burst_launch_bench.sv
module udma_burst_launch_bench;
  localparam int CLK_PER = 10;
  localparam int DW = 16;
  localparam int TS = 3, TD = 2, TU = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic src_valid = 1'b0, host_ack_n = 1'b1, host_stop = 1'b1, host_rdy_n = 1'b1;
  logic [DW-1:0] src_word = '0;
  logic src_take, dev_req, bus_data_oe, dev_strobe, dev_strobe_oe;
  logic [DW-1:0] bus_data;
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PER/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  udma_burst_launch #(.DW(DW), .STB_EN_CYC(TS), .DATA_EN_CYC(TD), .SETUP_CYC(TU)) u_udma_burst_launch (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_word(src_word), .src_take(src_take),
    .dev_req(dev_req), .host_ack_n(host_ack_n), .host_stop(host_stop), .host_rdy_n(host_rdy_n),
    .bus_data(bus_data), .bus_data_oe(bus_data_oe), .dev_strobe(dev_strobe),
    .dev_strobe_oe(dev_strobe_oe));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic run(input int ad, input int rd, input bit abort, input logic [DW-1:0] w);
    int ea, er, es, ed, ef, ex;
    ea = 2 + ad;
    er = ea + 1 + rd;
    es = ea + TS;
    ed = er + TD;
    ef = (ed + TU > es + 1) ? ed + TU : es + 1;
    ex = abort ? er + 1 : ef + 3;
    src_word = w;
    for (int e = 1; e <= ex + 1; e++) begin
      src_valid  = (e < ex);
      host_ack_n = !(e >= ea && e < ex);
      host_stop  = !(e < ex && (rd == 0 || e >= er));
      host_rdy_n = !(e < ex && (rd == 0 || e >= er));
      @(negedge clk);
      chk("R2 request", dev_req, (e >= 1 && e < ex));
      chk("R4 strobe enable", dev_strobe_oe, (e >= es && e < ex));
      chk("R5 R6 R3 data enable", bus_data_oe, (e >= ed && e < ex));
      if (e >= es && e < ex) chk("R7 R8 strobe level", dev_strobe, (e < ef));
      if (e >= ed && e < ex) chk("R5 R11 data word", bus_data, w);
      chk("R7 R10 take", src_take, (!abort && e == ef));
      if (e >= ex) chk("R9 release", {dev_req, dev_strobe_oe, bus_data_oe}, 3'b000);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {dev_req, dev_strobe_oe, bus_data_oe, src_take}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {dev_req, dev_strobe_oe, bus_data_oe, src_take}, 4'b0000);
    for (int a = 0; a < 3; a++)
      for (int r = 0; r < 4; r++)
        for (int b = 0; b < 2; b++)
          run(a, r, b[0], 16'hA5C3 ^ 16'((a * 37 + r * 11 + b * 5) * 257));
    repeat (2) @(negedge clk);
    chk("R2 idle", dev_req, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PER * 20000);
    fails++; checks++;
    $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule